// File: doc/BRIEF.md
# Memory-to-Peripheral DMA Channel with Buffer Reload

This block is one DMA channel. It reads data units from memory and passes them to a peripheral transmit port. Software programs an active buffer (a start address and a count of data units) and can also queue a second buffer in a reload pair. When the active count runs out, the hardware moves the reload pair into the active pair. The next buffer starts at the normal beat rate, with no extra gap. Each data unit is a byte, a halfword or a word.

In normal mode the reload pair is cleared after the move. An "reload empty" status then reports that the queue is empty, so an interrupt handler can queue the next buffer. This gives double buffering, or a ring of any number of buffers when the handler picks the address. In loop mode the reload pair is not cleared, so the same buffer sequence repeats until software disables the channel. When a buffer ends with nothing queued, the channel stops and sets a completion flag.

Each beat takes two cycles. In the first cycle the channel issues a one-cycle memory read. In the second cycle it offers the data to the peripheral lane chosen by the peripheral-select field, and holds it there until that lane accepts it.

Top module: `dma_reload_channel`

## Requirements
- R1: After reset, every register reads zero except the status register, which reads 1 (reload empty). `irq`, `mem_rd_en` and all `tx_valid` lanes are low.
- R2: Each beat does the following:
  - It raises `mem_rd_en` for one cycle, with `mem_addr` equal to the current address.
  - In the next cycle it presents `mem_rdata` on `tx_data`.
  - It keeps `tx_valid` and `tx_data` unchanged until the selected lane's `tx_ready` is high.
- R3: Each accepted beat adds a step to the current address (register 1) and subtracts 1 from the current count (register 2). The step is set by the size field, CTRL bits 3:2:
  - code 0: step 1 (byte)
  - code 1: step 2 (halfword)
  - code 2: step 4 (word)
- R4: When a beat brings the current count to zero and the reload count (register 4) is nonzero, the reload address (register 3) and the reload count are copied into the current pair. The next beat follows at the same two-cycle cadence as beats inside a buffer.
- R5: With loop mode off (CTRL bit 1 = 0), the reload address and the reload count read zero after the copy.
- R6: Status bit 0 (register 6) reads 1 exactly when the reload count is zero. Writing a nonzero reload count makes it read 0.
- R7: With loop mode on, the copy leaves the reload pair unchanged, so the buffer sequence repeats with no end.
- R8: Status bit 1 (done) is set when a beat brings the current count to zero and the reload count is zero. The channel then stops issuing beats. Writing 1 to status bit 1 clears it.
- R9: `irq` is high when one of these holds:
  - status bit 0 is set and interrupt-enable bit 0 (register 5) is set;
  - status bit 1 is set and interrupt-enable bit 1 is set.
- R10: CTRL bit 0 enables the channel. While it is 0, no new beat starts and the current pair holds its value; a beat already offered to the peripheral still completes. Setting the bit to 1 again resumes the transfer where it stopped.
- R11: CTRL bits 4 and up select the peripheral lane. Only that lane's `tx_valid` is ever raised. Only that lane's `tx_ready` completes a beat.
- R12: When the channel is enabled and the current count is zero, writing a nonzero reload count loads the reload pair into the current pair and starts transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select. 0 CTRL, 1 current address, 2 current count, 3 reload address, 4 reload count, 5 interrupt enable, 6 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_addr` (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 32 | Memory data. Valid in the cycle after the request and held until the next request |
| tx_valid | output | NUM_PERIPH | Per-lane data-valid signal to the peripheral |
| tx_ready | input | NUM_PERIPH | Per-lane data-accept signal from the peripheral |
| tx_data | output | 32 | Data unit sent to the peripheral |
| tx_size | output | 2 | Size code of the data unit |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume the following about the inputs:
- The memory returns read data in the cycle after a request and holds it until the next request.
- Software changes the size and lane-select fields only while the channel is disabled.
- Software writes the current pair only while the channel is idle or disabled.

The bench's memory model registers a value derived from the address on each request, and keeps it unchanged between requests. Every scenario clears the enable bit before it rewrites the size or lane fields or the current pair. The reload pair is written at any time, which this block permits.

// File: rtl/dma_reload_pkg.sv
// Package: shared types for the reload DMA channel.
// Assumes: the register map is indexed by word and is three bits wide.
package dma_reload_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        SEL_CTRL     = 3'd0,
        SEL_CUR_ADDR = 3'd1,
        SEL_CUR_CNT  = 3'd2,
        SEL_RLD_ADDR = 3'd3,
        SEL_RLD_CNT  = 3'd4,
        SEL_IRQ_EN   = 3'd5,
        SEL_STATUS   = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_SEND  = 2'd2
    } eng_state_e;

    // Address step for one data unit; the reserved code behaves as word.
    function automatic logic [2:0] size_step(input xfer_size_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs
// Holds the control register, the current and reload address/count pairs,
// the interrupt enables and the done flag. Performs the reload copy.
// Assumes: xfer_done pulses only while cur_cnt is nonzero, and software
// writes the current pair only while the channel is idle or disabled.
module dma_chan_regs
    import dma_reload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int PID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              xfer_done,
    output logic              enable,
    output xfer_size_e        size,
    output logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [CNT_W-1:0]  rld_cnt,
    output logic              irq
);

    logic              ring;
    logic [ADDR_W-1:0] rld_addr;
    logic [1:0]        irq_en;
    logic              done_flag;
    logic              rld_empty;
    logic              last_beat;
    logic              copy_expiry;
    logic              copy_idle;
    logic              copy_hit;
    logic              wr_ctrl, wr_cur_addr, wr_cur_cnt;
    logic              wr_rld_addr, wr_rld_cnt, wr_irq_en, wr_status;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    // Decode which register a write targets.
    always_comb begin
        wr_ctrl     = wr_en && (sel == SEL_CTRL);
        wr_cur_addr = wr_en && (sel == SEL_CUR_ADDR);
        wr_cur_cnt  = wr_en && (sel == SEL_CUR_CNT);
        wr_rld_addr = wr_en && (sel == SEL_RLD_ADDR);
        wr_rld_cnt  = wr_en && (sel == SEL_RLD_CNT);
        wr_irq_en   = wr_en && (sel == SEL_IRQ_EN);
        wr_status   = wr_en && (sel == SEL_STATUS);
    end

    // Reload conditions: on expiry of the active buffer, or while idle.
    always_comb begin
        rld_empty   = (rld_cnt == '0);
        last_beat   = xfer_done && (cur_cnt == CNT_W'(1));
        copy_expiry = last_beat && !rld_empty;
        copy_idle   = enable && (cur_cnt == '0) && !rld_empty;
        copy_hit    = copy_expiry || copy_idle;
    end

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            ring   <= 1'b0;
            size   <= SZ_BYTE;
            pid    <= '0;
            irq_en <= '0;
        end else begin
            if (wr_ctrl) begin
                enable <= wdata[0];
                ring   <= wdata[1];
                size   <= xfer_size_e'(wdata[3:2]);
                pid    <= wdata[4 +: PID_W];
            end
            if (wr_irq_en) irq_en <= wdata[1:0];
        end
    end

    // Current pair: reload copy, then per-beat step, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (copy_hit) begin
            cur_addr <= rld_addr;
            cur_cnt  <= rld_cnt;
        end else if (xfer_done) begin
            cur_addr <= cur_addr + ADDR_W'(size_step(size));
            cur_cnt  <= cur_cnt - CNT_W'(1);
        end else begin
            if (wr_cur_addr) cur_addr <= wdata[ADDR_W-1:0];
            if (wr_cur_cnt)  cur_cnt  <= wdata[CNT_W-1:0];
        end
    end

    // Reload pair: software write wins, else cleared after a copy unless looping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_addr <= '0;
            rld_cnt  <= '0;
        end else begin
            if (wr_rld_addr)           rld_addr <= wdata[ADDR_W-1:0];
            else if (copy_hit && !ring) rld_addr <= '0;
            if (wr_rld_cnt)            rld_cnt  <= wdata[CNT_W-1:0];
            else if (copy_hit && !ring) rld_cnt  <= '0;
        end
    end

    // Done flag: set when a buffer ends with nothing queued, write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_flag <= 1'b0;
        else if (last_beat && rld_empty) done_flag <= 1'b1;
        else if (wr_status && wdata[1])  done_flag <= 1'b0;
    end

    // Read mux and interrupt combine.
    always_comb begin
        case (sel)
            SEL_CTRL:     rdata = 32'({pid, size, ring, enable});
            SEL_CUR_ADDR: rdata = 32'(cur_addr);
            SEL_CUR_CNT:  rdata = 32'(cur_cnt);
            SEL_RLD_ADDR: rdata = 32'(rld_addr);
            SEL_RLD_CNT:  rdata = 32'(rld_cnt);
            SEL_IRQ_EN:   rdata = 32'(irq_en);
            SEL_STATUS:   rdata = 32'({done_flag, rld_empty});
            default:      rdata = '0;
        endcase
        irq = (rld_empty && irq_en[0]) || (done_flag && irq_en[1]);
    end

    // A beat that does not end the buffer steps the count down by one.
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && cur_cnt > CNT_W'(1)) |=> (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    // Without loop mode, the reload count is empty after a copy.
    assert_rld_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_hit && !ring && !wr_rld_cnt) |=> (rld_cnt == '0));

    // In loop mode, a copy leaves the reload count as it was.
    assert_ring_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_hit && ring && !wr_rld_cnt) |=> $stable(rld_cnt));

    // An expiry copy loads the queued count into the current count.
    assert_copy_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        copy_expiry |=> (cur_cnt == $past(rld_cnt)));

endmodule

// File: rtl/dma_chan_engine.sv
// Module: dma_chan_engine
// Sequences each beat as a memory fetch followed by a send on the selected
// peripheral lane, and chains beats while work remains.
// Assumes: mem_rdata is valid the cycle after mem_rd_en and is held until
// the next request; pid and size change only while the channel is disabled.
module dma_chan_engine
    import dma_reload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int NUM_PERIPH = 4,
    parameter int PID_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  xfer_size_e            size,
    input  logic [PID_W-1:0]      pid,
    input  logic [ADDR_W-1:0]     cur_addr,
    input  logic [CNT_W-1:0]      cur_cnt,
    input  logic [CNT_W-1:0]      rld_cnt,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [31:0]           mem_rdata,
    output logic [NUM_PERIPH-1:0] tx_valid,
    input  logic [NUM_PERIPH-1:0] tx_ready,
    output logic [31:0]           tx_data,
    output logic [1:0]            tx_size,
    output logic                  xfer_done
);

    eng_state_e state;
    logic       sending;
    logic       more;

    assign sending   = (state == ENG_SEND);
    assign mem_rd_en = (state == ENG_FETCH);
    assign mem_addr  = cur_addr;
    assign tx_data   = mem_rdata;
    assign tx_size   = size;
    assign xfer_done = |(tx_valid & tx_ready);
    assign more      = (cur_cnt > CNT_W'(1)) || (rld_cnt != '0);

    // One valid line for each peripheral lane, raised only for the selected lane.
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_lane
        assign tx_valid[i] = sending && (pid == PID_W'(i));
    end

    // Beat sequencer: idle, fetch, send, then chain or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
        end else begin
            case (state)
                ENG_IDLE:  if (enable && cur_cnt != '0) state <= ENG_FETCH;
                ENG_FETCH: state <= ENG_SEND;
                ENG_SEND:  if (xfer_done) state <= (enable && more) ? ENG_FETCH : ENG_IDLE;
                default:   state <= ENG_IDLE;
            endcase
        end
    end

    // An offered unit stays offered until it is accepted.
    assert_valid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tx_valid) && !xfer_done) |=> (tx_valid == $past(tx_valid)));

    // A fetch never starts while the channel is disabled.
    assert_fetch_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(enable));

    // At most one lane is offered data at a time.
    assert_lane_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_valid));

    // A beat completes only against a nonzero current count.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (cur_cnt != '0));

endmodule

// File: rtl/dma_reload_channel.sv
// Module: dma_reload_channel (top)
// One memory-to-peripheral DMA channel with a current and a reload buffer
// descriptor. Joins the register block and the beat engine.
// Assumes: ADDR_W <= 32 and CNT_W <= 32; NUM_PERIPH >= 1.
module dma_reload_channel
    import dma_reload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic [2:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [31:0]           mem_rdata,
    output logic [NUM_PERIPH-1:0] tx_valid,
    input  logic [NUM_PERIPH-1:0] tx_ready,
    output logic [31:0]           tx_data,
    output logic [1:0]            tx_size,
    output logic                  irq
);

    localparam int PID_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;

    logic              enable;
    xfer_size_e        size;
    logic [PID_W-1:0]  pid;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CNT_W-1:0]  rld_cnt;
    logic              xfer_done;

    dma_chan_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PID_W  (PID_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .sel       (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .xfer_done (xfer_done),
        .enable    (enable),
        .size      (size),
        .pid       (pid),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .rld_cnt   (rld_cnt),
        .irq       (irq)
    );

    dma_chan_engine #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .NUM_PERIPH (NUM_PERIPH),
        .PID_W      (PID_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .size      (size),
        .pid       (pid),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .rld_cnt   (rld_cnt),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_size   (tx_size),
        .xfer_done (xfer_done)
    );

endmodule

// File: tb/dma_reload_channel_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module dma_reload_channel_bench;

    localparam logic [31:0] DATA_KEY = 32'h5A00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  tx_valid;
    logic [3:0]  tx_ready = 4'hF;
    logic [31:0] tx_data;
    logic [1:0]  tx_size;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int beat_n = 0;
    int hold_err = 0;
    logic [31:0] beat_addr [128];
    logic [3:0]  beat_lane [128];
    int          beat_cyc  [128];
    logic        prev_stall = 1'b0;
    logic [3:0]  prev_valid = '0;
    logic [31:0] prev_data = '0;

    always #4 clk = ~clk;

    dma_reload_channel u_dma_reload_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_size(tx_size), .irq(irq)
    );

    // Memory model: one-cycle read latency, data held between requests.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) mem_rdata <= mem_addr ^ DATA_KEY;
    end

    // Beat monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && (tx_valid != prev_valid || tx_data != prev_data))
                hold_err++;
            if (|(tx_valid & tx_ready)) begin
                beat_addr[beat_n & 127] = tx_data ^ DATA_KEY;
                beat_lane[beat_n & 127] = tx_valid;
                beat_cyc[beat_n & 127]  = cyc;
                beat_n++;
            end
            prev_stall = (|tx_valid) && !(|(tx_valid & tx_ready));
            prev_valid = tx_valid;
            prev_data  = tx_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] val);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = sel; reg_wdata = val;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        reg_addr = sel; #1;
        val = reg_rdata;
    endtask

    task automatic wait_beats(input int target);
        for (int t = 0; t < 3000 && beat_n < target; t++) @(posedge clk);
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic expect_run(input string req, input int base, input int n,
                              input logic [31:0] start, input logic [31:0] step,
                              input logic [3:0] lane);
        for (int i = 0; i < n; i++) begin
            check(req, beat_addr[(base + i) & 127], start + step * i);
            check("R11", {28'd0, beat_lane[(base + i) & 127]}, {28'd0, lane});
        end
    endtask

    // R1: state after reset.
    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            check("R1 reg", v, 32'd0);
        end
        rd(3'd6, v);
        check("R1 status", v, 32'd1);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx_valid", {28'd0, tx_valid}, 32'd0);
        check("R1 mem_rd_en", {31'd0, mem_rd_en}, 32'd0);
    endtask

    // R2 R3 R8: word buffer on lane 1, then done flag set and cleared.
    task automatic t_word();
        logic [31:0] v;
        int base = beat_n;
        wr(3'd1, 32'h100); wr(3'd2, 32'd4);
        wr(3'd0, 32'h1 | (2 << 2) | (1 << 4));
        wait_beats(base + 4);
        check("R2 beat count", beat_n - base, 32'd4);
        expect_run("R2", base, 4, 32'h100, 32'd4, 4'b0010);
        rd(3'd1, v); check("R3 addr after", v, 32'h110);
        rd(3'd2, v); check("R3 cnt after", v, 32'd0);
        rd(3'd6, v); check("R8 done set", v, 32'd3);
        wr(3'd6, 32'd2);
        rd(3'd6, v); check("R8 done w1c", v, 32'd1);
    endtask

    // R3: byte and halfword steps.
    task automatic t_sizes();
        logic [31:0] v;
        int base;
        wr(3'd0, 32'd0);
        base = beat_n;
        wr(3'd1, 32'h200); wr(3'd2, 32'd3);
        wr(3'd0, 32'h1 | (0 << 2) | (0 << 4));
        wait_beats(base + 3);
        expect_run("R3 byte", base, 3, 32'h200, 32'd1, 4'b0001);
        wr(3'd0, 32'd0);
        base = beat_n;
        wr(3'd1, 32'h300); wr(3'd2, 32'd3);
        wr(3'd0, 32'h1 | (1 << 2) | (2 << 4));
        wait_beats(base + 3);
        expect_run("R3 half", base, 3, 32'h300, 32'd2, 4'b0100);
        rd(3'd1, v); check("R3 half addr", v, 32'h306);
        wr(3'd0, 32'd0);
        wr(3'd6, 32'd2);
    endtask

    // R4 R5 R6: chained buffers with constant cadence.
    task automatic t_chain();
        logic [31:0] v;
        int base = beat_n;
        wr(3'd1, 32'h400); wr(3'd2, 32'd3);
        wr(3'd3, 32'h800); wr(3'd4, 32'd2);
        rd(3'd6, v); check("R6 queued clears empty", v, 32'd0);
        wr(3'd0, 32'h1 | (2 << 2) | (3 << 4));
        wait_beats(base + 5);
        check("R4 beat count", beat_n - base, 32'd5);
        expect_run("R4", base, 3, 32'h400, 32'd4, 4'b1000);
        expect_run("R4", base + 3, 2, 32'h800, 32'd4, 4'b1000);
        for (int i = 1; i < 5; i++)
            check("R4 cadence", beat_cyc[(base + i) & 127] - beat_cyc[(base + i - 1) & 127], 32'd2);
        rd(3'd3, v); check("R5 rld addr cleared", v, 32'd0);
        rd(3'd4, v); check("R5 rld cnt cleared", v, 32'd0);
        rd(3'd6, v); check("R6 empty after copy", v, 32'd3);
        rd(3'd1, v); check("R4 addr after", v, 32'h808);
        wr(3'd0, 32'd0);
        wr(3'd6, 32'd2);
    endtask

    // R2: stalls hold the offered unit.
    task automatic t_backpressure();
        int base = beat_n;
        hold_err = 0;
        tx_ready = 4'h0;
        wr(3'd1, 32'h600); wr(3'd2, 32'd3);
        wr(3'd0, 32'h1 | (2 << 2) | (0 << 4));
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            tx_ready = (k % 5 == 4) ? 4'hF : 4'h0;
        end
        tx_ready = 4'hF;
        wait_beats(base + 3);
        check("R2 stalled count", beat_n - base, 32'd3);
        expect_run("R2 stall", base, 3, 32'h600, 32'd4, 4'b0001);
        check("R2 hold", hold_err, 32'd0);
        wr(3'd0, 32'd0);
        wr(3'd6, 32'd2);
    endtask

    // R7 R10: loop mode repeats; disabling freezes the channel.
    task automatic t_ring();
        logic [31:0] v, a0, c0;
        int base = beat_n;
        int n0;
        wr(3'd1, 32'hA00); wr(3'd2, 32'd2);
        wr(3'd3, 32'hA00); wr(3'd4, 32'd2);
        wr(3'd0, 32'h1 | 32'h2 | (2 << 2) | (1 << 4));
        for (int t = 0; t < 3000 && beat_n < base + 7; t++) @(posedge clk);
        #1;
        for (int i = 0; i < 7; i++)
            check("R7 loop addr", beat_addr[(base + i) & 127], 32'hA00 + 4 * (i % 2));
        rd(3'd3, v); check("R7 rld addr kept", v, 32'hA00);
        rd(3'd4, v); check("R7 rld cnt kept", v, 32'd2);
        rd(3'd6, v); check("R7 never done", v, 32'd0);
        wr(3'd0, 32'h2 | (2 << 2) | (1 << 4));
        repeat (3) @(posedge clk);
        #1;
        n0 = beat_n;
        rd(3'd1, a0); rd(3'd2, c0);
        repeat (20) @(posedge clk);
        #1;
        check("R10 no beats when off", beat_n, n0);
        rd(3'd1, v); check("R10 addr held", v, a0);
        rd(3'd2, v); check("R10 cnt held", v, c0);
        wr(3'd0, 32'd0);
        wr(3'd4, 32'd0); wr(3'd3, 32'd0);
    endtask

    // R10: pause mid-buffer, then resume.
    task automatic t_gate();
        logic [31:0] v;
        int base = beat_n;
        int n;
        wr(3'd1, 32'hC00); wr(3'd2, 32'd10);
        wr(3'd0, 32'h1 | (2 << 2));
        for (int t = 0; t < 3000 && beat_n < base + 3; t++) @(posedge clk);
        #1;
        wr(3'd0, 32'h0 | (2 << 2));
        repeat (3) @(posedge clk);
        #1;
        n = beat_n - base;
        rd(3'd1, v); check("R10 paused addr", v, 32'hC00 + 4 * n);
        rd(3'd2, v); check("R10 paused cnt", v, 32'(10 - n));
        repeat (20) @(posedge clk);
        #1;
        check("R10 paused beats", beat_n - base, n);
        wr(3'd0, 32'h1 | (2 << 2));
        wait_beats(base + 10);
        check("R10 resumed total", beat_n - base, 32'd10);
        expect_run("R10 resume", base, 10, 32'hC00, 32'd4, 4'b0001);
        wr(3'd0, 32'd0);
    endtask

    // R6 R8 R9: interrupt masking of each flag.
    task automatic t_irq();
        wr(3'd5, 32'd1);
        check("R9 empty enabled", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'd5);
        check("R6 R9 queued drops irq", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'd0);
        check("R9 empty again", {31'd0, irq}, 32'd1);
        wr(3'd5, 32'd2);
        check("R9 done enabled", {31'd0, irq}, 32'd1);
        wr(3'd6, 32'd2);
        check("R8 R9 done cleared", {31'd0, irq}, 32'd0);
        wr(3'd5, 32'd0);
    endtask

    // R12: idle channel starts when a reload buffer is queued.
    task automatic t_idle_resume();
        logic [31:0] v;
        int base = beat_n;
        wr(3'd0, 32'h1 | (2 << 2) | (2 << 4));
        repeat (5) @(posedge clk);
        #1;
        check("R12 idle no beats", beat_n - base, 32'd0);
        wr(3'd3, 32'hE00); wr(3'd4, 32'd2);
        wait_beats(base + 2);
        check("R12 count", beat_n - base, 32'd2);
        expect_run("R12", base, 2, 32'hE00, 32'd4, 4'b0100);
        rd(3'd4, v); check("R12 R5 rld cleared", v, 32'd0);
        rd(3'd6, v); check("R12 R8 done", v, 32'd3);
    endtask

    initial begin
        bit timed_out = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        fork
            begin
                t_reset();
                t_word();
                t_sizes();
                t_chain();
                t_backpressure();
                t_ring();
                t_gate();
                t_irq();
                t_idle_resume();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule